// File: doc/BRIEF.md
# Segmented Effective-to-Linear Address Translator

This block converts an effective address into a linear address through one of six segment registers, and checks the access while it does so. It keeps a small descriptor file with one entry per segment register. Each entry holds a 16-bit visible selector, a base, a lower bound and an upper bound. A synchronous write port loads the entries. Computing the bounds from descriptor attributes is left to the code that drives this port.

A request carries four fields: a processor mode, a signed 64-bit effective address, a segment index and an access size in bytes. One cycle later the block raises a valid strobe with the linear address and an error code.

In 64-bit mode, only the FS and GS entries add their base, and the result must be canonical. In 32-bit mode the block rejects null selectors on data segments. It also requires the whole byte range of the access to lie inside the segment bounds, and it never wraps around the end of the segment.

Segment indices are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5. Mode 0 is 64-bit and mode 1 is 32-bit. Error codes are 0 none, 1 non-canonical, 2 null selector, 3 limit fail, 4 unimplemented mode and 5 illegal size.

Top module: `seg_xlat_top`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and a cycle without a request produces `rsp_valid` low in the next cycle. After reset, `rsp_valid` is 0, `rsp_la` is 0 and `rsp_err` is 0.
- R2: In mode 0, segments 4 and 5 yield (base + effective address) modulo 2^64. All other segments pass the effective address through unchanged.
- R3: In mode 0, a result whose bits 63 down to 47 are not all equal reports error 1.
- R4: In mode 0, neither the selector value nor the segment bounds are checked.
- R5: In mode 1, a segment other than 1 (CS) or 2 (SS) whose selector is in the range 0..3 reports error 2. A non-zero requested privilege in bits 1:0 does not exempt the selector.
- R6: In mode 1, the effective address, taken as signed, must be at least the 33-bit lower bound. The effective address plus size minus 1, computed without truncation, must be at most the 32-bit upper bound. If either test fails, the block reports error 3, so an access cannot wrap past the segment end.
- R7: In mode 1, a successful result is (base[31:0] + effective address[31:0]) modulo 2^32, zero-extended to 64 bits.
- R8: Only sizes of 1, 2, 4, 6, 8, 10, 16, 32 and 64 bytes are legal. Any other size in mode 0 or mode 1 reports error 5.
- R9: Any mode value other than 0 or 1 reports error 4.
- R10: When several errors apply, the block reports the first in this order: mode (4), size (5), null selector (2), limit (3). Non-canonical (1) applies only in mode 0, after size.
- R11: Whenever the error code is non-zero, `rsp_la` is 0.
- R12: A write to entry 0..5 takes effect for a request in the following cycle. A write with index 6 or 7 changes no entry. A request naming index 6 or 7 reads an all-zero entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Descriptor write enable |
| wr_idx | input | 3 | Entry to write |
| wr_sel | input | 16 | Visible selector value |
| wr_base | input | 64 | Segment base |
| wr_lo | input | 33 | Lower bound |
| wr_hi | input | 32 | Upper bound |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Processor mode |
| req_ea | input | 64 | Signed effective address |
| req_seg | input | 3 | Segment index |
| req_nbytes | input | 7 | Access size in bytes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_la | output | 64 | Linear address, zero on error |
| rsp_err | output | 3 | Error code |

## Verification
The bench targets the cases that separate a correct translator from a plausible wrong one.

- An 8-byte access near the top of a 4 GiB segment has a last byte above 2^32. A design that truncates the last-byte sum would let it through instead of reporting a limit fail.
- A negative effective address in 32-bit mode must fail the lower bound. An unsigned compare would accept it.
- A GS base sum that carries out of bit 63 must wrap. Addresses just either side of the canonical boundary must be classified correctly.
- A selector of 3 and an SS entry with selector 0 probe the null rule. A design that ignores the exemption would fault on SS.
- Requests that trip two errors at once expose a wrong priority order.
- A write to index 6 would corrupt entry 2 in a design that drops the top index bit.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   localparam int SEG_CNT   = 6;
   localparam int SEG_IDX_W = 3;

   localparam logic [SEG_IDX_W-1:0] SEG_CS = 3'd1;
   localparam logic [SEG_IDX_W-1:0] SEG_SS = 3'd2;
   localparam logic [SEG_IDX_W-1:0] SEG_FS = 3'd4;
   localparam logic [SEG_IDX_W-1:0] SEG_GS = 3'd5;

   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_LONG = 3'd0;
   localparam logic [MODE_W-1:0] MODE_PROT = 3'd1;

   typedef enum logic [2:0] {
      XERR_NONE     = 3'd0,
      XERR_NONCANON = 3'd1,
      XERR_NULLSEL  = 3'd2,
      XERR_LIMIT    = 3'd3,
      XERR_MODE     = 3'd4,
      XERR_SIZE     = 3'd5
   } xlat_err_e;

   // Access sizes accepted by the translator.
   function automatic logic size_is_legal(input logic [6:0] n);
      case (n)
         7'd1, 7'd2, 7'd4, 7'd6, 7'd8, 7'd10, 7'd16, 7'd32, 7'd64: size_is_legal = 1'b1;
         default:                                                 size_is_legal = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file #(
   parameter int N      = 6,
   parameter int IDX_W  = 3,
   parameter int SEL_W  = 16,
   parameter int BASE_W = 64,
   parameter int LO_W   = 33,
   parameter int HI_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LO_W-1:0]   wr_lo,
   input  logic [HI_W-1:0]   wr_hi,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SEL_W-1:0]  rd_sel,
   output logic [BASE_W-1:0] rd_base,
   output logic [LO_W-1:0]   rd_lo,
   output logic [HI_W-1:0]   rd_hi
);

   logic [SEL_W-1:0]  sel_q  [N];
   logic [BASE_W-1:0] base_q [N];
   logic [LO_W-1:0]   lo_q   [N];
   logic [HI_W-1:0]   hi_q   [N];

   for (genvar e = 0; e < N; e++) begin : g_entry
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q[e]  <= '0;
            base_q[e] <= '0;
            lo_q[e]   <= '0;
            hi_q[e]   <= '0;
         end else if (wr_en && wr_idx == MY_IDX) begin
            sel_q[e]  <= wr_sel;
            base_q[e] <= wr_base;
            lo_q[e]   <= wr_lo;
            hi_q[e]   <= wr_hi;
         end
      end
   end

   // Indices past the last entry read as an all-zero descriptor.
   always_comb begin
      rd_sel  = '0;
      rd_base = '0;
      rd_lo   = '0;
      rd_hi   = '0;
      for (int e = 0; e < N; e++) begin
         if (rd_idx == IDX_W'(e)) begin
            rd_sel  = sel_q[e];
            rd_base = base_q[e];
            rd_lo   = lo_q[e];
            rd_hi   = hi_q[e];
         end
      end
   end

endmodule

// File: rtl/seg_path_long.sv
module seg_path_long #(
   parameter int EA_W    = 64,
   parameter int BASE_W  = 64,
   parameter int CANON_W = 48
) (
   input  logic [EA_W-1:0]   ea,
   input  logic [BASE_W-1:0] base,
   input  logic              add_base,
   output logic [EA_W-1:0]   la,
   output logic              canon_ok
);

   localparam int TOP_BITS = EA_W - CANON_W + 1;

   logic [EA_W-1:0]     base_ext;
   logic [TOP_BITS-1:0] top;

   if (BASE_W == EA_W) begin : g_base_full
      assign base_ext = base;
   end else begin : g_base_zext
      assign base_ext = {{(EA_W-BASE_W){1'b0}}, base};
   end

   assign la       = add_base ? (ea + base_ext) : ea;
   assign top      = la[EA_W-1:CANON_W-1];
   assign canon_ok = (&top) | ~(|top);

endmodule

// File: rtl/seg_path_prot.sv
module seg_path_prot #(
   parameter int EA_W  = 64,
   parameter int SEL_W = 16,
   parameter int PA_W  = 32,
   parameter int LO_W  = 33,
   parameter int HI_W  = 32,
   parameter int NB_W  = 7
) (
   input  logic [EA_W-1:0]  ea,
   input  logic [NB_W-1:0]  nbytes,
   input  logic [SEL_W-1:0] sel,
   input  logic [PA_W-1:0]  base,
   input  logic [LO_W-1:0]  lo,
   input  logic [HI_W-1:0]  hi,
   input  logic             exempt,
   output logic             null_hit,
   output logic             limit_fail,
   output logic [EA_W-1:0]  la
);

   localparam int CMP_W = EA_W + 2;

   logic signed [CMP_W-1:0] first_s, last_s, nb_s, one_s, lo_s, hi_s;
   logic [PA_W-1:0]         sum;

   assign first_s = {{2{ea[EA_W-1]}}, ea};
   assign nb_s    = {{(CMP_W-NB_W){1'b0}}, nbytes};
   assign one_s   = {{(CMP_W-1){1'b0}}, 1'b1};
   assign last_s  = first_s + nb_s - one_s;
   assign lo_s    = {{(CMP_W-LO_W){1'b0}}, lo};
   assign hi_s    = {{(CMP_W-HI_W){1'b0}}, hi};

   // Selector values 0..3 are null whatever the privilege bits say.
   assign null_hit   = !exempt && (sel[SEL_W-1:2] == '0);
   assign limit_fail = (first_s < lo_s) || (last_s > hi_s);

   assign sum = base + ea[PA_W-1:0];
   assign la  = {{(EA_W-PA_W){1'b0}}, sum};

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top #(
   parameter int EA_W    = 64,
   parameter int BASE_W  = 64,
   parameter int PA_W    = 32,
   parameter int SEL_W   = 16,
   parameter int LO_W    = 33,
   parameter int HI_W    = 32,
   parameter int NB_W    = 7,
   parameter int CANON_W = 48
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [seg_xlat_pkg::SEG_IDX_W-1:0] wr_idx,
   input  logic [SEL_W-1:0]                 wr_sel,
   input  logic [BASE_W-1:0]                wr_base,
   input  logic [LO_W-1:0]                  wr_lo,
   input  logic [HI_W-1:0]                  wr_hi,
   input  logic                             req_valid,
   input  logic [seg_xlat_pkg::MODE_W-1:0]  req_mode,
   input  logic [EA_W-1:0]                  req_ea,
   input  logic [seg_xlat_pkg::SEG_IDX_W-1:0] req_seg,
   input  logic [NB_W-1:0]                  req_nbytes,
   output logic                             rsp_valid,
   output logic [EA_W-1:0]                  rsp_la,
   output logic [2:0]                       rsp_err
);
   import seg_xlat_pkg::*;

   if (BASE_W < PA_W || BASE_W > EA_W) begin : g_bad_base
      $error("seg_xlat_top: BASE_W must lie between PA_W and EA_W");
   end
   if (CANON_W < 2 || CANON_W > EA_W) begin : g_bad_canon
      $error("seg_xlat_top: CANON_W out of range");
   end
   if (NB_W != 7) begin : g_bad_nb
      $error("seg_xlat_top: NB_W must be 7");
   end
   if (LO_W != PA_W + 1 || HI_W != PA_W) begin : g_bad_bounds
      $error("seg_xlat_top: bound widths must follow PA_W");
   end

   logic [SEL_W-1:0]  d_sel;
   logic [BASE_W-1:0] d_base;
   logic [LO_W-1:0]   d_lo;
   logic [HI_W-1:0]   d_hi;

   seg_desc_file #(
      .N(SEG_CNT), .IDX_W(SEG_IDX_W), .SEL_W(SEL_W),
      .BASE_W(BASE_W), .LO_W(LO_W), .HI_W(HI_W)
   ) u_desc (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
      .wr_base(wr_base), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .rd_idx(req_seg),
      .rd_sel(d_sel), .rd_base(d_base), .rd_lo(d_lo), .rd_hi(d_hi)
   );

   logic [EA_W-1:0] long_la;
   logic            long_canon;
   logic            fsgs;

   assign fsgs = (req_seg == SEG_FS) || (req_seg == SEG_GS);

   seg_path_long #(
      .EA_W(EA_W), .BASE_W(BASE_W), .CANON_W(CANON_W)
   ) u_long (
      .ea(req_ea), .base(d_base), .add_base(fsgs),
      .la(long_la), .canon_ok(long_canon)
   );

   logic [EA_W-1:0] prot_la;
   logic            prot_null, prot_limit, exempt;

   assign exempt = (req_seg == SEG_CS) || (req_seg == SEG_SS);

   seg_path_prot #(
      .EA_W(EA_W), .SEL_W(SEL_W), .PA_W(PA_W),
      .LO_W(LO_W), .HI_W(HI_W), .NB_W(NB_W)
   ) u_prot (
      .ea(req_ea), .nbytes(req_nbytes), .sel(d_sel),
      .base(d_base[PA_W-1:0]), .lo(d_lo), .hi(d_hi), .exempt(exempt),
      .null_hit(prot_null), .limit_fail(prot_limit), .la(prot_la)
   );

   xlat_err_e       err_d;
   logic [EA_W-1:0] la_d;

   always_comb begin
      if (req_mode != MODE_LONG && req_mode != MODE_PROT) begin
         err_d = XERR_MODE;
      end else if (!size_is_legal(req_nbytes)) begin
         err_d = XERR_SIZE;
      end else if (req_mode == MODE_LONG) begin
         err_d = long_canon ? XERR_NONE : XERR_NONCANON;
      end else if (prot_null) begin
         err_d = XERR_NULLSEL;
      end else if (prot_limit) begin
         err_d = XERR_LIMIT;
      end else begin
         err_d = XERR_NONE;
      end
   end

   always_comb begin
      if (err_d != XERR_NONE)         la_d = '0;
      else if (req_mode == MODE_LONG) la_d = long_la;
      else                            la_d = prot_la;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_la    <= '0;
         rsp_err   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_la  <= la_d;
            rsp_err <= err_d;
         end
      end
   end

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
   parameter int EA_W    = 64,
   parameter int NB_W    = 7,
   parameter int CANON_W = 48
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [2:0]      req_mode,
   input logic [NB_W-1:0] req_nbytes,
   input logic            rsp_valid,
   input logic [EA_W-1:0] rsp_la,
   input logic [2:0]      rsp_err
);

   logic canon_out;
   assign canon_out = (&rsp_la[EA_W-1:CANON_W-1]) | ~(|rsp_la[EA_W-1:CANON_W-1]);

   p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_no_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_err_zero_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err != 3'd0) |-> rsp_la == '0);

   p_good_is_canon_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err == 3'd0) |-> canon_out);

   p_prot_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd1) |=> rsp_la[EA_W-1:32] == '0);

   p_long_no_seg_checks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd0) |=> (rsp_err != 3'd2 && rsp_err != 3'd3));

   p_bad_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode > 3'd1) |=> rsp_err == 3'd4);

   p_err_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_err <= 3'd5);

   p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode <= 3'd1 && req_nbytes == 7'd3) |=> rsp_err == 3'd5);

endmodule

bind seg_xlat_top seg_xlat_chk #(
   .EA_W(EA_W), .NB_W(NB_W), .CANON_W(CANON_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
   .req_nbytes(req_nbytes), .rsp_valid(rsp_valid), .rsp_la(rsp_la), .rsp_err(rsp_err)
);

// File: tb/tb_seg_xlat_top.sv
module tb_seg_xlat_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [15:0] wr_sel = '0;
   logic [63:0] wr_base = '0;
   logic [32:0] wr_lo = '0;
   logic [31:0] wr_hi = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic [63:0] req_ea = '0;
   logic [2:0]  req_seg = '0;
   logic [6:0]  req_nbytes = '0;
   logic        rsp_valid;
   logic [63:0] rsp_la;
   logic [2:0]  rsp_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlat_top dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
      .wr_base(wr_base), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .req_valid(req_valid), .req_mode(req_mode), .req_ea(req_ea),
      .req_seg(req_seg), .req_nbytes(req_nbytes),
      .rsp_valid(rsp_valid), .rsp_la(rsp_la), .rsp_err(rsp_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load(input logic [2:0] idx, input logic [15:0] sel, input logic [63:0] base,
                       input logic [32:0] lo, input logic [31:0] hi);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_base = base; wr_lo = lo; wr_hi = hi;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic xlat(input logic [2:0] mode, input logic [63:0] ea, input logic [2:0] seg,
                       input logic [6:0] nb, input logic [63:0] exp_la, input logic [2:0] exp_err,
                       input string req);
      @(negedge clk);
      req_valid = 1'b1; req_mode = mode; req_ea = ea; req_seg = seg; req_nbytes = nb;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, req, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
      check(rsp_err == exp_err, req, "rsp_err", {61'd0, rsp_err}, {61'd0, exp_err});
      check(rsp_la == exp_la, req, "rsp_la", rsp_la, exp_la);
   endtask

   task automatic t_reset;
      check(rsp_valid == 1'b0 && rsp_la == '0 && rsp_err == '0, "R1", "reset state",
            {rsp_valid, rsp_err, rsp_la[59:0]}, 64'd0);
   endtask

   task automatic t_setup;
      load(3'd0, 16'h0010, 64'h0000_0000_FFFF_F000, 33'd0, 32'h0000_FFFF);
      load(3'd1, 16'h0008, 64'd0, 33'd0, 32'hFFFF_FFFF);
      load(3'd2, 16'h0000, 64'h2000, 33'h100, 32'h1FFF);
      load(3'd3, 16'h0003, 64'd0, 33'd0, 32'd0);
      load(3'd4, 16'h0000, 64'h0000_7000_0000_0000, 33'd0, 32'd0);
      load(3'd5, 16'h0000, 64'hFFFF_FFFF_0000_0000, 33'd0, 32'd0);
   endtask

   task automatic t_long_mode;
      xlat(3'd0, 64'h1234, 3'd3, 7'd4, 64'h1234, 3'd0, "R2_R4 passthrough null DS");
      xlat(3'd0, 64'h10, 3'd4, 7'd8, 64'h0000_7000_0000_0010, 3'd0, "R2 FS base");
      xlat(3'd0, 64'h1_0000_0010, 3'd5, 7'd8, 64'h10, 3'd0, "R2 GS wrap mod 2^64");
      xlat(3'd0, 64'h0000_1000_0000_0000, 3'd4, 7'd1, 64'd0, 3'd1, "R3_R11 FS non-canonical");
      xlat(3'd0, 64'hFFFF_8000_0000_0000, 3'd0, 7'd1, 64'hFFFF_8000_0000_0000, 3'd0, "R3 low canonical");
      xlat(3'd0, 64'h0000_8000_0000_0000, 3'd0, 7'd1, 64'd0, 3'd1, "R3 just past canonical");
      xlat(3'd0, 64'h0001_0000, 3'd2, 7'd64, 64'h0001_0000, 3'd0, "R4 no bounds in long mode");
      xlat(3'd0, 64'h5, 3'd7, 7'd2, 64'h5, 3'd0, "R12 index 7 long passthrough");
   endtask

   task automatic t_prot_mode;
      xlat(3'd1, 64'h20, 3'd0, 7'd4, 64'hFFFF_F020, 3'd0, "R7 ES base add");
      xlat(3'd1, 64'h2000, 3'd0, 7'd1, 64'h1000, 3'd0, "R7 mod 2^32 wrap");
      xlat(3'd1, 64'h10, 3'd3, 7'd1, 64'd0, 3'd2, "R5 selector 3 is null");
      xlat(3'd1, 64'h100, 3'd2, 7'd8, 64'h2100, 3'd0, "R5 SS exempt");
      xlat(3'd1, 64'hFF, 3'd2, 7'd1, 64'd0, 3'd3, "R6 below lower bound");
      xlat(3'd1, 64'h1FFC, 3'd2, 7'd4, 64'h3FFC, 3'd0, "R6 last byte at upper bound");
      xlat(3'd1, 64'h1FFC, 3'd2, 7'd8, 64'd0, 3'd3, "R6 last byte past upper bound");
      xlat(3'd1, 64'hFFFF_FFFC, 3'd1, 7'd4, 64'hFFFF_FFFC, 3'd0, "R6 top of 4GiB");
      xlat(3'd1, 64'hFFFF_FFFC, 3'd1, 7'd8, 64'd0, 3'd3, "R6 no wrap past 4GiB");
      xlat(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 7'd1, 64'd0, 3'd3, "R6 negative ea");
      xlat(3'd1, 64'h0, 3'd7, 7'd1, 64'd0, 3'd2, "R12 index 7 reads zero entry");
   endtask

   task automatic t_errors;
      xlat(3'd1, 64'h0, 3'd1, 7'd3, 64'd0, 3'd5, "R8 size 3 prot");
      xlat(3'd0, 64'h0, 3'd3, 7'd12, 64'd0, 3'd5, "R8 size 12 long");
      xlat(3'd1, 64'h40, 3'd1, 7'd10, 64'h40, 3'd0, "R8 size 10 legal");
      xlat(3'd2, 64'h0, 3'd0, 7'd1, 64'd0, 3'd4, "R9 mode 2");
      xlat(3'd3, 64'h0, 3'd0, 7'd3, 64'd0, 3'd4, "R10 mode beats size");
      xlat(3'd1, 64'h10, 3'd3, 7'd3, 64'd0, 3'd5, "R10 size beats null");
      xlat(3'd1, 64'h10, 3'd3, 7'd4, 64'd0, 3'd2, "R10 null beats limit");
      xlat(3'd0, 64'h0000_8000_0000_0000, 3'd0, 7'd5, 64'd0, 3'd5, "R10 size beats canonical");
   endtask

   task automatic t_writes;
      load(3'd6, 16'hFFFF, 64'h1234_5678, 33'h1000, 32'h0);
      xlat(3'd1, 64'h100, 3'd2, 7'd8, 64'h2100, 3'd0, "R12 index 6 write ignored");
      load(3'd2, 16'h0000, 64'h9000, 33'h0, 32'hFFFF);
      xlat(3'd1, 64'h10, 3'd2, 7'd2, 64'h9010, 3'd0, "R12 write seen next cycle");
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "no response when idle", {63'd0, rsp_valid}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_setup();
      t_long_mode();
      t_prot_mode();
      t_errors();
      t_writes();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule